// File: doc/BRIEF.md
# Serial NOR Flash 64 KB Block-Erase Sequencer

This block sits on the host side of a four-wire SPI link to a serial NOR flash. A single start pulse, together with a 24-bit byte address, launches one complete 64 KB block erase. The block runs three kinds of chip-select frame in order:

- a one-byte write-enable frame;
- an erase frame carrying the erase opcode and three address bytes;
- one or more status-read frames.

Status reads repeat, with a wait between them, until the flash reports that it is no longer busy. The block then pulses `done`. If the flash is still busy after a set number of reads, the block pulses `timeout_err` instead.

The flash ignores an erase aimed at a protected block without reporting an error. In that case the first status read already shows the flash idle, and the request ends with `done` after one poll. The serial clock is the system clock divided down. The link runs in mode 0: the clock idles low, MOSI is updated after falling edges and MISO is captured on rising edges.

Top module: `spi_blk_erase_seq`

## Requirements
- R1: After an accepted start, the first frame is exactly 8 bits long and carries the write-enable opcode 0x06. Chip select rises again before any other frame begins.
- R2: The second frame carries the erase opcode 0xD8 and then 24 address bits, most significant bit first, for 32 bits in all. Chip select stays low across all 32 bits and rises only after the last one.
- R3: In the erase frame, the second byte equals address bits 23..16. The third and fourth bytes are always 0x00, whatever the low 16 address bits hold.
- R4: Each following frame is 16 bits long. It is the read-status opcode 0x05 followed by one byte clocked in from MISO. Bit 0 of that byte is the busy flag (1 = busy), and bits 7..1 are ignored.
- R5: While busy reads 1, a new status frame follows. Chip select stays high for at least CS_GAP+POLL_WAIT cycles between two status frames. When busy reads 0, `done` pulses for exactly one cycle.
- R6: If MAX_POLLS status reads in a row all report busy, `timeout_err` pulses for one cycle, `done` stays low and no further frame is sent.
- R7: A start pulse that arrives while `busy` is high is ignored. The frame count and the erase address are those of the first request.
- R8: `busy` rises in the cycle after an accepted start. It falls in the same cycle that `done` or `timeout_err` pulses. `done` and `timeout_err` are never high together. A start given in the cycle where `done` is high is accepted.
- R9: SCLK is low whenever chip select is high. MOSI never changes at a rising SCLK edge.
- R10: Chip select stays high for at least CS_GAP system cycles between any two frames of one request.
- R11: During and just after reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0 and `timeout_err`=0.
- R12: A flash that reports not-busy on the first status read (the protected-block case) ends the request with `done` after exactly one status frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to erase the block holding `addr` |
| addr | input | 24 | Byte address inside the target 64 KB block |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse: flash reported the erase complete |
| timeout_err | output | 1 | One-cycle pulse: poll limit reached while still busy |
| sclk | output | 1 | SPI serial clock, idles low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The end of one request and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` in exactly the cycle where `done` is high. It then expects `busy` to rise again on the following clock and a full, correctly addressed new frame chain to follow. A second overlap is a start that lands in the middle of an erase. It must leave both the busy trace and the captured frames of the running request untouched. A behavioural flash model decodes every frame from the pins and answers status reads from a countdown, so that the busy and protected cases can be told apart.

// File: rtl/bes_pkg.sv
package bes_pkg;

    localparam int ADDR_W   = 24;
    localparam int BLK_LSB  = 16;
    localparam int BUSY_BIT = 0;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_ERASE = 8'hD8;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    typedef enum logic [1:0] {
        FR_WREN,
        FR_ERASE,
        FR_STAT
    } frame_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_XFER,
        S_GAP,
        S_WAIT
    } seq_e;

    typedef struct packed {
        frame_e     kind;
        logic [1:0] idx;
    } cursor_t;

    // Byte to shift out for a given frame and byte position.
    function automatic logic [7:0] frame_byte(frame_e k, logic [1:0] i,
                                              logic [ADDR_W-1:0] a);
        logic [7:0] b;
        b = 8'h00;
        case (k)
            FR_WREN:  b = OP_WREN;
            FR_ERASE: begin
                if (i == 2'd0)      b = OP_ERASE;
                else if (i == 2'd1) b = a[ADDR_W-1:BLK_LSB];
                else                b = 8'h00;
            end
            FR_STAT:  b = (i == 2'd0) ? OP_RDSR : 8'h00;
            default:  b = 8'h00;
        endcase
        return b;
    endfunction

    // Index of the final byte in each frame.
    function automatic logic [1:0] frame_last(frame_e k);
        case (k)
            FR_WREN:  return 2'd0;
            FR_ERASE: return 2'd3;
            default:  return 2'd1;
        endcase
    endfunction

    function automatic logic status_busy(logic [7:0] s);
        return s[BUSY_BIT];
    endfunction

endpackage

// File: rtl/bes_timer.sv
module bes_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/bes_spi_byte.sv
module bes_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [HW-1:0] half_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    sr;
    logic [7:0]    rx;
    logic          active;
    logic          sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt  <= '0;
            bit_cnt   <= '0;
            sr        <= '0;
            rx        <= '0;
            active    <= 1'b0;
            sclk_q    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (go) begin
                sr       <= tx_byte;
                active   <= 1'b1;
                half_cnt <= '0;
                bit_cnt  <= '0;
                sclk_q   <= 1'b0;
            end else if (active) begin
                if (half_cnt == HW'(HALF_DIV - 1)) begin
                    half_cnt <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx     <= {rx[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_cnt == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 3'd1;
                            sr      <= {sr[6:0], 1'b0};
                        end
                    end
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = sr[7];
    assign rx_byte = rx;
endmodule

// File: rtl/spi_blk_erase_seq.sv
module spi_blk_erase_seq
    import bes_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int CS_GAP    = 4,
    parameter int POLL_WAIT = 6,
    parameter int MAX_POLLS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int TMAX = (CS_GAP > POLL_WAIT) ? CS_GAP : POLL_WAIT;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(MAX_POLLS + 1);

    seq_e              st;
    cursor_t           cur;
    logic [ADDR_W-1:0] addr_q;
    logic              cs_q, busy_q, done_q, to_q, stat_busy;
    logic [PW-1:0]     poll_cnt;

    logic              go, byte_done, tmr_load, tmr_zero, last_byte;
    logic [7:0]        tx_byte, rx_byte;
    logic [TW-1:0]     tmr_val;

    bes_spi_byte #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .go(go), .tx_byte(tx_byte), .miso(miso),
        .sclk(sclk), .mosi(mosi), .rx_byte(rx_byte), .byte_done(byte_done)
    );

    bes_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
    );

    assign last_byte = (cur.idx == frame_last(cur.kind));

    always_comb begin
        go       = 1'b0;
        tx_byte  = frame_byte(cur.kind, cur.idx, addr_q);
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_LOAD: go = 1'b1;
            S_XFER: if (byte_done && last_byte) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(CS_GAP);
            end
            S_GAP: if (tmr_zero && cur.kind == FR_STAT && stat_busy &&
                       poll_cnt != PW'(MAX_POLLS - 1)) begin
                tmr_load = 1'b1;
                tmr_val  = TW'(POLL_WAIT);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cur       <= cursor_t'{kind: FR_WREN, idx: 2'd0};
            addr_q    <= '0;
            cs_q      <= 1'b1;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            to_q      <= 1'b0;
            stat_busy <= 1'b0;
            poll_cnt  <= '0;
        end else begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    addr_q   <= addr;
                    cur      <= cursor_t'{kind: FR_WREN, idx: 2'd0};
                    cs_q     <= 1'b0;
                    busy_q   <= 1'b1;
                    poll_cnt <= '0;
                    st       <= S_LOAD;
                end
                S_LOAD: st <= S_XFER;
                S_XFER: if (byte_done) begin
                    if (cur.kind == FR_STAT && cur.idx == 2'd1)
                        stat_busy <= status_busy(rx_byte);
                    if (last_byte) begin
                        cs_q <= 1'b1;
                        st   <= S_GAP;
                    end else begin
                        cur.idx <= cur.idx + 2'd1;
                        st      <= S_LOAD;
                    end
                end
                S_GAP: if (tmr_zero) begin
                    case (cur.kind)
                        FR_WREN: begin
                            cur  <= cursor_t'{kind: FR_ERASE, idx: 2'd0};
                            cs_q <= 1'b0;
                            st   <= S_LOAD;
                        end
                        FR_ERASE: begin
                            cur  <= cursor_t'{kind: FR_STAT, idx: 2'd0};
                            cs_q <= 1'b0;
                            st   <= S_LOAD;
                        end
                        default: begin
                            if (!stat_busy) begin
                                done_q <= 1'b1;
                                busy_q <= 1'b0;
                                st     <= S_IDLE;
                            end else if (poll_cnt == PW'(MAX_POLLS - 1)) begin
                                to_q   <= 1'b1;
                                busy_q <= 1'b0;
                                st     <= S_IDLE;
                            end else begin
                                poll_cnt <= poll_cnt + 1'b1;
                                st       <= S_WAIT;
                            end
                        end
                    endcase
                end
                S_WAIT: if (tmr_zero) begin
                    cur  <= cursor_t'{kind: FR_STAT, idx: 2'd0};
                    cs_q <= 1'b0;
                    st   <= S_LOAD;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign cs_n        = cs_q;
    assign busy        = busy_q;
    assign done        = done_q;
    assign timeout_err = to_q;
endmodule

// File: rtl/bes_chk.sv
module bes_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic timeout_err,
    input logic sclk,
    input logic cs_n,
    input logic mosi
);
    // R9
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R9
    mosi_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi));

    // R9
    cs_edge_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n) |-> !sclk);

    // R8
    end_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout_err));

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || timeout_err));

    // R8
    end_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (done || timeout_err) |-> !busy);

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    to_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err);
endmodule

bind spi_blk_erase_seq bes_chk u_bes_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .timeout_err(timeout_err), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/tb_spi_blk_erase_seq.sv
`timescale 1ns/100ps
module tb_spi_blk_erase_seq;
    localparam int HALF_DIV  = 2;
    localparam int CS_GAP    = 4;
    localparam int POLL_WAIT = 6;
    localparam int MAX_POLLS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] addr = '0;
    logic        busy, done, timeout_err, sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    spi_blk_erase_seq #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP),
                        .POLL_WAIT(POLL_WAIT), .MAX_POLLS(MAX_POLLS)) dut (
        .clk(clk), .rst(rst), .start(start), .addr(addr), .busy(busy),
        .done(done), .timeout_err(timeout_err), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural flash model
    logic [7:0]  fl_op = 8'h00;
    int          fl_bits = 0;
    logic [31:0] fl_sh = '0;
    int          busy_left = 0;
    logic [31:0] fr_data[$];
    int          fr_bits[$];
    int          fr_gap[$];
    int          hi_cnt = 0;

    always @(negedge cs_n) begin
        fl_bits = 0;
        fl_sh   = '0;
        fl_op   = 8'h00;
    end

    always @(posedge sclk) begin
        fl_sh = {fl_sh[30:0], mosi};
        fl_bits++;
        if (fl_bits == 8) fl_op = fl_sh[7:0];
    end

    always @(negedge sclk) begin
        logic [7:0] st_b;
        st_b = (busy_left > 0) ? 8'h01 : 8'hFE;
        if (!cs_n && fl_bits >= 8 && fl_bits < 16 && fl_op == 8'h05)
            miso = st_b[15 - fl_bits];
    end

    always @(posedge cs_n) begin
        miso = 1'b0;
        if (fl_bits > 0) begin
            fr_data.push_back(fl_sh);
            fr_bits.push_back(fl_bits);
            if (fl_op == 8'h05 && busy_left > 0) busy_left--;
        end
    end

    always @(posedge clk) begin
        if (cs_n) hi_cnt++;
        else if (hi_cnt > 0) begin
            fr_gap.push_back(hi_cnt);
            hi_cnt = 0;
        end
    end

    // Reference model of busy, checked every clock
    logic exp_busy = 1'b0;
    int   err_r8 = 0;
    int   err_r9 = 0;
    logic prev_end = 1'b0;

    always @(posedge clk) begin
        if (rst) exp_busy <= 1'b0;
        else if (start && !exp_busy) exp_busy <= 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (done || timeout_err) begin
                if (busy !== 1'b0) err_r8++;
                if (done && timeout_err) err_r8++;
                if (prev_end) err_r8++;
                exp_busy = 1'b0;
            end else if (busy !== exp_busy) err_r8++;
            prev_end = done || timeout_err;
            if (cs_n && sclk) err_r9++;
        end
    end

    task automatic launch(input logic [23:0] a, input int polls);
        fr_data.delete();
        fr_bits.delete();
        fr_gap.delete();
        hi_cnt    = 10000;
        busy_left = polls;
        addr  = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input int inject, input logic [23:0] other,
                            output bit got_done, output bit got_to);
        got_done = 1'b0;
        got_to   = 1'b0;
        for (int n = 1; n <= 20000; n++) begin
            if (done || timeout_err) begin
                got_done = done;
                got_to   = timeout_err;
                break;
            end
            if (n == inject) begin
                start = 1'b1;
                addr  = other;
            end else if (n == inject + 1) begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(got_done || got_to, "R5 request finished", 0, 1);
    endtask

    task automatic analyse(input logic [23:0] a, input int polls, input bit exp_to,
                           input bit got_done, input bit got_to);
        int exp_stat;
        exp_stat = exp_to ? MAX_POLLS : polls + 1;
        check(fr_data.size() == 2 + exp_stat, exp_to ? "R6 frame count" :
              (polls == 0 ? "R12 frame count" : "R5 frame count"),
              fr_data.size(), 2 + exp_stat);
        if (fr_data.size() >= 2) begin
            check(fr_bits[0] == 8 && fr_data[0][7:0] == 8'h06, "R1 wren frame",
                  fr_data[0][7:0], 8'h06);
            check(fr_bits[1] == 32 && fr_data[1][31:24] == 8'hD8, "R2 erase frame",
                  fr_bits[1], 32);
            check(fr_data[1][23:0] == {a[23:16], 16'h0000}, "R3 erase address",
                  fr_data[1][23:0], {a[23:16], 16'h0000});
            for (int i = 2; i < fr_data.size(); i++)
                check(fr_bits[i] == 16 && fr_data[i][15:8] == 8'h05, "R4 status frame",
                      fr_data[i][15:8], 8'h05);
        end
        for (int i = 1; i < fr_gap.size(); i++)
            check(fr_gap[i] >= CS_GAP, "R10 cs gap", fr_gap[i], CS_GAP);
        for (int i = 3; i < fr_gap.size(); i++)
            check(fr_gap[i] >= CS_GAP + POLL_WAIT, "R5 poll wait", fr_gap[i],
                  CS_GAP + POLL_WAIT);
        check(got_done == !exp_to, exp_to ? "R6 no done" : "R5 done pulse",
              got_done, !exp_to);
        check(got_to == exp_to, "R6 timeout flag", got_to, exp_to);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("[TB] FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit d, t;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 &&
              done === 1'b0 && timeout_err === 1'b0, "R11 reset outputs",
              {cs_n, sclk, busy, done, timeout_err}, 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R11 after reset", {cs_n, busy}, 2'b10);

        // Normal erase, three busy polls
        launch(24'h3A5C71, 3);
        wait_end(0, 24'h0, d, t);
        analyse(24'h3A5C71, 3, 1'b0, d, t);
        @(negedge clk);

        // R12 protected block: idle on first read
        launch(24'hFFFFFF, 0);
        wait_end(0, 24'h0, d, t);
        analyse(24'hFFFFFF, 0, 1'b0, d, t);
        @(negedge clk);

        // R6 timeout
        launch(24'h01ABCD, 1000);
        wait_end(0, 24'h0, d, t);
        analyse(24'h01ABCD, 0, 1'b1, d, t);
        @(negedge clk);

        // R7 start while busy is ignored
        launch(24'h120000, 2);
        wait_end(120, 24'h7F5555, d, t);
        analyse(24'h120000, 2, 1'b0, d, t);
        @(negedge clk);

        // R8 start in the cycle done is high
        launch(24'h44FFFF, 1);
        wait_end(0, 24'h0, d, t);
        analyse(24'h44FFFF, 1, 1'b0, d, t);
        launch(24'h9900AA, 0);
        check(busy === 1'b1, "R8 restart on done cycle", busy, 1);
        wait_end(0, 24'h0, d, t);
        analyse(24'h9900AA, 0, 1'b0, d, t);
        @(negedge clk);
        @(negedge clk);

        check(err_r8 == 0, "R8 busy trace and pulses", err_r8, 0);
        check(err_r9 == 0, "R9 sclk low while deselected", err_r9, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule